// File: doc/BRIEF.md
# ATM Cell Receive Width Converter

This block sits on the receive side of a cell-level PHY interface. On its user side it pulls 16-bit words out of a cell buffer. It drives a read strobe and a word address, and it watches a flag that says a whole cell is waiting. On the link side it presents one 8-bit cell byte per accepted clock, a start-of-cell marker and a cell-available indication. All of these are synchronous to the receive clock. The link layer paces the flow with an active-low enable and can stall the transfer at any cycle.

A cell is 27 buffer words. Each word is sent upper byte first. In 53-byte mode the lower byte of the third word is dropped, so a cell is 53 bytes on the link. In 54-byte mode all 54 bytes are sent. The read strobe has a one-clock gap after each word, because one word feeds two byte cycles. There is no gap where the dropped byte would have been. Cells follow each other with no idle byte slot when the buffer still reports a cell and the link still enables. Reset is synchronous and active high.

Top module: `atm_rx_width_conv`

## Requirements
- R1: While no cell is in progress, a transfer starts only in a cycle where `usr_cell_avail` is 1 and `utp_rx_enb_n` is 0. In that cycle `usr_rd_en` is 1 for address 0.
- R2: Once a cell has started, all of its bytes are delivered even if `usr_cell_avail` falls during the cell.
- R3: `usr_word_addr` never exceeds 27 (0x1B). It reads 27 once the last word (address 26) has been taken. It returns to 0 on the clock that delivers the last byte of the cell.
- R4: `usr_rd_en` is high for single clocks. `usr_word` is captured on the rising edge that ends a clock where `usr_rd_en` is high, and `usr_word_addr` is one larger after that edge.
- R5: Within a cell, `usr_rd_en` is high on the clock that delivers each word's upper byte and low on the clock that delivers its lower byte. In 53-byte mode the word at address 3 is fetched on the clock right after the one that took address 2, with no gap.
- R6: Bytes appear on `utp_rx_data` as `usr_word[15:8]` then `usr_word[7:0]` of each word, in address order 0 to 26.
- R7: When `cell54_mode` is 0, the lower byte of the word at address 2 is never driven, and a cell is 53 bytes. When `cell54_mode` is 1, a cell is 54 bytes.
- R8: `utp_rx_soc` is 1 exactly while the upper byte of address 0 is on `utp_rx_data`, and 0 otherwise.
- R9: If `usr_cell_avail` is 1 and `utp_rx_enb_n` is 0 on the clock that delivers a cell's last byte, the next clock with `utp_rx_enb_n` at 0 delivers the first byte of the next cell.
- R10: In a clock where `utp_rx_enb_n` is 1, `usr_rd_en` is 0, and `utp_rx_data` and `utp_rx_soc` do not change on the following edge.
- R11: `utp_rx_clav` equals `usr_cell_avail` delayed by one clock.
- R12: While `rst` is 1, all registered outputs return to 0 and `usr_rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous reset, active high |
| usr_cell_avail | input | 1 | Buffer holds a complete cell |
| usr_rd_en | output | 1 | Word read strobe to the buffer |
| usr_word_addr | output | 5 | Word address within the cell |
| usr_word | input | 16 | Word returned by the buffer for `usr_word_addr` |
| cell54_mode | input | 1 | 1: 54-byte cells, 0: 53-byte cells |
| utp_rx_enb_n | input | 1 | Link-layer receive enable, active low |
| utp_rx_data | output | 8 | Cell byte to the link layer |
| utp_rx_soc | output | 1 | Marks the first byte of a cell |
| utp_rx_clav | output | 1 | Cell-available indication to the link layer |

## Verification
Two things can happen in the same clock: the last byte of a cell goes out, and the next cell is committed (address reset plus start-of-cell on the following accepted byte). In the same way, the byte that precedes the dropped header byte goes out while the next word is fetched with no gap. The bench provokes both with long runs where the enable stays low and cells are always available, in both cell modes. It also uses pseudo-random stall patterns that land the enable's rising edge on exactly those clocks. Each clock it compares data, marker, address and strobe against a byte-index model built from the requirements. A missed commit shows up as a lost marker or a stale address, and a gap at the drop point shows up as a wrong byte.

// File: rtl/atm_rxw_pkg.sv
package atm_rxw_pkg;

    localparam int unsigned DEF_WORD_W     = 16;
    localparam int unsigned DEF_CELL_WORDS = 27;
    localparam int unsigned DEF_DROP_WORD  = 2;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_CELL = 1'b1
    } seq_mode_e;

    // per-clock control handed from the sequencer to the byte datapath
    typedef struct packed {
        logic emit;   // a byte is placed on the link bus at this edge
        logic take;   // the buffer word is captured at this edge
        logic first;  // the emitted byte is the first of a cell
    } emit_ctl_t;

    function automatic int unsigned last_byte_idx(input int unsigned words);
        return 2 * words - 1;
    endfunction

    function automatic int unsigned drop_byte_idx(input int unsigned word);
        return 2 * word + 1;
    endfunction

endpackage

// File: rtl/atm_rxw_seq.sv
module atm_rxw_seq
    import atm_rxw_pkg::*;
#(
    parameter int unsigned CELL_WORDS = DEF_CELL_WORDS,
    parameter int unsigned DROP_WORD  = DEF_DROP_WORD,
    parameter int unsigned IDX_W      = 6,
    parameter int unsigned ADDR_W     = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cell_avail,
    input  logic              enb_n,
    input  logic              full_cell,
    output emit_ctl_t         ctl,
    output logic              advance,
    output logic [ADDR_W-1:0] word_addr
);

    localparam int unsigned LAST_IDX = last_byte_idx(CELL_WORDS);
    localparam int unsigned SKIP_IDX = drop_byte_idx(DROP_WORD) - 1;

    seq_mode_e         state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ADDR_W-1:0] addr_q;

    logic [IDX_W-1:0]  cur_idx;
    logic [IDX_W-1:0]  nxt_idx;
    logic              emit;
    logic              take;
    logic              at_last;

    always_comb begin
        cur_idx = (state_q == SEQ_CELL) ? idx_q : '0;
        advance = !rst && !enb_n;
        emit    = advance && ((state_q == SEQ_CELL) || cell_avail);
        take    = emit && !cur_idx[0];
        at_last = (cur_idx == IDX_W'(LAST_IDX));
        if (!full_cell && (cur_idx == IDX_W'(SKIP_IDX)))
            nxt_idx = cur_idx + IDX_W'(2);
        else
            nxt_idx = cur_idx + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            idx_q   <= '0;
            addr_q  <= '0;
        end else if (emit) begin
            if (at_last) begin
                state_q <= cell_avail ? SEQ_CELL : SEQ_IDLE;
                idx_q   <= '0;
                addr_q  <= '0;
            end else begin
                state_q <= SEQ_CELL;
                idx_q   <= nxt_idx;
                if (take)
                    addr_q <= addr_q + ADDR_W'(1);
            end
        end
    end

    assign ctl.emit  = emit;
    assign ctl.take  = take;
    assign ctl.first = (cur_idx == '0);
    assign word_addr = addr_q;

endmodule

// File: rtl/atm_rxw_pack.sv
module atm_rxw_pack
    import atm_rxw_pkg::*;
#(
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                advance,
    input  emit_ctl_t           ctl,
    input  logic [WORD_W-1:0]   word,
    output logic [WORD_W/2-1:0] byte_out,
    output logic                soc_out
);

    localparam int unsigned BYTE_W = WORD_W / 2;

    logic [BYTE_W-1:0] lo_hold_q;
    logic [BYTE_W-1:0] hi_part;
    logic [BYTE_W-1:0] lo_part;

    assign hi_part = word[WORD_W-1 -: BYTE_W];
    assign lo_part = word[BYTE_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_hold_q <= '0;
            byte_out  <= '0;
            soc_out   <= 1'b0;
        end else begin
            if (ctl.emit) begin
                byte_out <= ctl.take ? hi_part : lo_hold_q;
                if (ctl.take)
                    lo_hold_q <= lo_part;
            end
            if (advance)
                soc_out <= ctl.emit && ctl.first;
        end
    end

endmodule

// File: rtl/atm_rxw_clav.sv
module atm_rxw_clav (
    input  logic clk,
    input  logic rst,
    input  logic avail_in,
    output logic clav_out
);

    always_ff @(posedge clk) begin
        if (rst)
            clav_out <= 1'b0;
        else
            clav_out <= avail_in;
    end

endmodule

// File: rtl/atm_rx_width_conv.sv
module atm_rx_width_conv
    import atm_rxw_pkg::*;
#(
    parameter int unsigned WORD_W     = DEF_WORD_W,
    parameter int unsigned CELL_WORDS = DEF_CELL_WORDS,
    parameter int unsigned DROP_WORD  = DEF_DROP_WORD,
    parameter int unsigned BYTE_W     = WORD_W / 2,
    parameter int unsigned ADDR_W     = $clog2(CELL_WORDS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              usr_cell_avail,
    output logic              usr_rd_en,
    output logic [ADDR_W-1:0] usr_word_addr,
    input  logic [WORD_W-1:0] usr_word,
    input  logic              cell54_mode,
    input  logic              utp_rx_enb_n,
    output logic [BYTE_W-1:0] utp_rx_data,
    output logic              utp_rx_soc,
    output logic              utp_rx_clav
);

    localparam int unsigned IDX_W = $clog2(2 * CELL_WORDS);

    emit_ctl_t ctl;
    logic      advance;

    atm_rxw_seq #(
        .CELL_WORDS (CELL_WORDS),
        .DROP_WORD  (DROP_WORD),
        .IDX_W      (IDX_W),
        .ADDR_W     (ADDR_W)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cell_avail (usr_cell_avail),
        .enb_n      (utp_rx_enb_n),
        .full_cell  (cell54_mode),
        .ctl        (ctl),
        .advance    (advance),
        .word_addr  (usr_word_addr)
    );

    atm_rxw_pack #(
        .WORD_W (WORD_W)
    ) u_pack (
        .clk      (clk),
        .rst      (rst),
        .advance  (advance),
        .ctl      (ctl),
        .word     (usr_word),
        .byte_out (utp_rx_data),
        .soc_out  (utp_rx_soc)
    );

    atm_rxw_clav u_clav (
        .clk      (clk),
        .rst      (rst),
        .avail_in (usr_cell_avail),
        .clav_out (utp_rx_clav)
    );

    assign usr_rd_en = ctl.take;

endmodule

// File: rtl/atm_rx_width_conv_chk.sv
module atm_rx_width_conv_chk #(
    parameter int unsigned CELL_WORDS = 27,
    parameter int unsigned BYTE_W     = 8,
    parameter int unsigned ADDR_W     = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              usr_cell_avail,
    input logic              usr_rd_en,
    input logic [ADDR_W-1:0] usr_word_addr,
    input logic              utp_rx_enb_n,
    input logic [BYTE_W-1:0] utp_rx_data,
    input logic              utp_rx_soc,
    input logic              utp_rx_clav
);

    p_fetch_gated_r10: assert property (@(posedge clk) disable iff (rst)
        usr_rd_en |-> !utp_rx_enb_n);

    p_stall_hold_r10: assert property (@(posedge clk) disable iff (rst)
        utp_rx_enb_n |=> ($stable(utp_rx_data) && $stable(utp_rx_soc)));

    p_clav_high_r11: assert property (@(posedge clk) disable iff (rst)
        usr_cell_avail |=> utp_rx_clav);

    p_clav_low_r11: assert property (@(posedge clk) disable iff (rst)
        !usr_cell_avail |=> !utp_rx_clav);

    p_addr_bound_r3: assert property (@(posedge clk) disable iff (rst)
        usr_word_addr <= ADDR_W'(CELL_WORDS));

    p_addr_step_r4: assert property (@(posedge clk) disable iff (rst)
        usr_rd_en |=> (usr_word_addr == $past(usr_word_addr) + ADDR_W'(1)));

    p_soc_origin_r8: assert property (@(posedge clk) disable iff (rst)
        usr_rd_en && (usr_word_addr == '0) |=> utp_rx_soc);

endmodule

bind atm_rx_width_conv atm_rx_width_conv_chk #(
    .CELL_WORDS (CELL_WORDS),
    .BYTE_W     (BYTE_W),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .usr_cell_avail (usr_cell_avail),
    .usr_rd_en      (usr_rd_en),
    .usr_word_addr  (usr_word_addr),
    .utp_rx_enb_n   (utp_rx_enb_n),
    .utp_rx_data    (utp_rx_data),
    .utp_rx_soc     (utp_rx_soc),
    .utp_rx_clav    (utp_rx_clav)
);

// File: tb/atm_rx_width_conv_bench.sv
module atm_rx_width_conv_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        usr_cell_avail;
    logic        usr_rd_en;
    logic [4:0]  usr_word_addr;
    logic [15:0] usr_word;
    logic        cell54_mode;
    logic        utp_rx_enb_n;
    logic [7:0]  utp_rx_data;
    logic        utp_rx_soc;
    logic        utp_rx_clav;
    logic [2:0]  seed;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    // buffer content: upper byte {seed,addr}, lower byte {addr,seed}
    assign usr_word = {seed, usr_word_addr, usr_word_addr, seed};

    atm_rx_width_conv u_atm_rx_width_conv (
        .clk            (clk),
        .rst            (rst),
        .usr_cell_avail (usr_cell_avail),
        .usr_rd_en      (usr_rd_en),
        .usr_word_addr  (usr_word_addr),
        .usr_word       (usr_word),
        .cell54_mode    (cell54_mode),
        .utp_rx_enb_n   (utp_rx_enb_n),
        .utp_rx_data    (utp_rx_data),
        .utp_rx_soc     (utp_rx_soc),
        .utp_rx_clav    (utp_rx_clav)
    );

    function automatic logic [7:0] exp_byte(input int i);
        logic [4:0] a;
        a = 5'(i / 2);
        return (i % 2 == 0) ? {seed, a} : {a, seed};
    endfunction

    // byte-index model of the link stream
    bit         mbusy, msoc, mclav, mstall, mb2b, mfree;
    int         midx, maddr, mi;
    logic [7:0] mdata;
    int         i;

    always @(posedge clk) begin
        if (rst) begin
            mbusy <= 0; midx <= 0; maddr <= 0; mdata <= '0; msoc <= 0;
            mclav <= 0; mstall <= 0; mi <= 0; mb2b <= 0; mfree <= 0;
        end else begin
            mclav  <= usr_cell_avail;
            mstall <= utp_rx_enb_n;
            if (!utp_rx_enb_n) begin
                if (!mbusy && !usr_cell_avail) begin
                    msoc <= 0;
                end else begin
                    i = mbusy ? midx : 0;
                    mdata <= exp_byte(i);
                    msoc  <= (i == 0);
                    mi    <= i;
                    mb2b  <= mbusy && (i == 0);
                    mfree <= mbusy && !usr_cell_avail;
                    if (i == 53) begin
                        mbusy <= usr_cell_avail;
                        midx  <= 0;
                        maddr <= 0;
                    end else begin
                        mbusy <= 1;
                        midx  <= (!cell54_mode && i == 4) ? 6 : i + 1;
                        if (i % 2 == 0) maddr <= maddr + 1;
                    end
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    bit prev_rd = 0;

    task automatic step(input logic e, input logic a);
        bit exp_rd;
        @(negedge clk);
        if (mstall)                         check("R10 data", utp_rx_data, mdata);
        else if (!cell54_mode && mi >= 6)   check("R7 data", utp_rx_data, mdata);
        else if (mfree)                     check("R2 data", utp_rx_data, mdata);
        else                                check("R6 data", utp_rx_data, mdata);
        check(mb2b ? "R9 soc" : "R8 soc", utp_rx_soc, msoc);
        check(prev_rd ? "R4 addr" : "R3 addr", usr_word_addr, maddr);
        check("R11 clav", utp_rx_clav, mclav);
        utp_rx_enb_n   = e;
        usr_cell_avail = a;
        #1;
        exp_rd = !e && (mbusy ? (midx % 2 == 0) : a);
        check(mbusy ? "R5 rd_en" : "R1 rd_en", usr_rd_en, exp_rd);
        prev_rd = exp_rd;
    endtask

    initial begin
        logic [15:0] lf;
        logic        e, a;
        lf = 16'hACE1;
        seed = 3'd5;
        cell54_mode = 1'b0;
        usr_cell_avail = 1'b1;
        utp_rx_enb_n = 1'b0;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 data", utp_rx_data, 0);
        check("R12 soc", utp_rx_soc, 0);
        check("R12 addr", usr_word_addr, 0);
        check("R12 clav", utp_rx_clav, 0);
        check("R12 rd_en", usr_rd_en, 0);
        rst = 1'b0;
        for (int md = 0; md < 2; md++) begin
            for (int pat = 0; pat < 4; pat++) begin
                for (int c = 0; c < 300; c++) begin
                    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                    case (pat)
                        0: begin e = 1'b0; a = 1'b1; end
                        1: begin e = (lf[1:0] == 2'b00); a = 1'b1; end
                        2: begin e = 1'b0; a = ((c / 37) % 2 == 0); end
                        default: begin e = lf[0] | lf[1]; a = lf[2]; end
                    endcase
                    step(e, a);
                end
                for (int k = 0; k < 200 && (mbusy || usr_rd_en); k++)
                    step(1'b0, 1'b0);
                step(1'b0, 1'b0);
                seed = seed + 3'd1;
            end
            cell54_mode = 1'b1;
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R12 watchdog actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule